// File: doc/BRIEF.md
# Prescaled 16-bit Overflow Timer

This block is a 16-bit up-counter reached from an 8-bit register bus. Software loads a start value, picks a count clock, and enables the overflow interrupt. The counter then advances on every count tick. When it steps from all ones to zero it sets a sticky overflow flag. The interrupt request is that flag gated by a mask bit and by a global enable input that comes from the processor's status logic.

The bus is only a byte wide, so the 16-bit count is moved in two accesses through one shared holding register for the upper byte. A write to the upper-byte address only fills the holding register. The later write to the lower-byte address moves both bytes into the counter on a single edge. A read of the lower byte copies the live upper byte into the holding register on the same edge, so a following read of the upper-byte address returns a byte that matches the lower byte already read.

The count clock comes from a small prescaler state machine with three states. PS_STOP produces no ticks. PS_DIV1 ticks on every clock. PS_DIV256 ticks once every 256 clocks, counted by an internal divider. The machine changes state only on a write to the clock-select field whose code differs from the current one. On that write it moves to the state that the new code decodes to and clears its divider. Any other write keeps the current state. Reset puts it in PS_STOP.

Top module: `tmr16_ovf_timer`

## Requirements
- R1: After reset, every register reads 0x00, the counter is 0x0000, the clock select is stopped, and `irq` is low.
- R2: On each count tick the counter increments by one. A tick at 0xFFFF wraps it to 0x0000 and sets bit 0 of the flag register (address 0x36) on the same edge.
- R3: Bits [2:0] of control B (address 0x81) select the count clock: 000 is stopped, 001 ticks every clock, 100 ticks every 256 clocks, and every other code is stopped. Bits [7:3] read back as 0.
- R4: A write of a clock-select code that differs from the current code restarts the prescaler. With code 100, the first increment lands 256 clocks after the edge that wrote the code.
- R5: A write to the high-byte address (0x85) changes only the holding register. The counter is not changed.
- R6: A write to the low-byte address (0x84) loads {holding register, written byte} into the counter on that edge. The load wins over a tick in the same cycle, and that cycle raises no overflow.
- R7: A read of address 0x84 returns the live low byte and copies the counter's high byte into the holding register on that edge. A read of 0x85 returns the holding register.
- R8: `irq` is high exactly when the overflow flag, bit 0 of the mask register (address 0x6F), and `gie` are all 1.
- R9: The overflow flag is cleared by writing a byte with bit 0 set to address 0x36, or by a one-cycle `irq_ack`. Writing 0 to bit 0 leaves the flag unchanged. A new overflow in the same cycle as a clear leaves the flag set.
- R10: Control A (address 0x80) stores and reads back any byte and has no effect on counting.
- R11: Reads of unmapped addresses return 0x00, writes to them change nothing, and `bus_rdata` is 0x00 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Clears the overflow flag |
| bus_rdata | output | 8 | Read data, combinational from address |
| irq | output | 1 | Overflow interrupt request |

## Verification
On every cycle the assertions check the following: the wrap to zero with the flag set, that the count holds while stopped, that a high-byte write touches only the holding register, that a low-byte write loads the counter and a low-byte read latches the high byte, that an acknowledge clears the flag, and that `irq` never rises without `gie`. Other behaviours show only in the bench's scenarios, which compare against a cycle-by-cycle reference model. These are the exact 256-clock spacing and the prescaler restart, the load that wins over a tick at 0xFFFF, the set-over-clear ordering on the flag, and the split read returning a matched byte pair while the counter keeps moving.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    typedef enum logic [1:0] {
        PS_STOP   = 2'd0,
        PS_DIV1   = 2'd1,
        PS_DIV256 = 2'd2
    } ps_mode_e;

    localparam logic [2:0] CS_STOP   = 3'b000;
    localparam logic [2:0] CS_DIV1   = 3'b001;
    localparam logic [2:0] CS_DIV256 = 3'b100;

    function automatic ps_mode_e cs_decode(input logic [2:0] code);
        ps_mode_e m;
        case (code)
            CS_DIV1:   m = PS_DIV1;
            CS_DIV256: m = PS_DIV256;
            default:   m = PS_STOP;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/tmr16_prescale.sv
module tmr16_prescale
    import tmr16_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_wr,
    input  logic [2:0] cs_new,
    input  logic [2:0] cs_cur,
    output logic       tick
);

    ps_mode_e         state_q;
    ps_mode_e         state_d;
    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] div_d;
    logic             restart;

    assign restart = cs_wr && (cs_new != cs_cur);

    // next state
    always_comb begin
        state_d = state_q;
        if (restart) begin
            state_d = cs_decode(cs_new);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_STOP;
            div_q   <= '0;
        end else begin
            state_q <= state_d;
            div_q   <= div_d;
        end
    end

    // outputs and divider
    always_comb begin
        tick  = 1'b0;
        div_d = '0;
        unique case (state_q)
            PS_STOP: begin
                tick  = 1'b0;
                div_d = '0;
            end
            PS_DIV1: begin
                tick  = 1'b1;
                div_d = '0;
            end
            PS_DIV256: begin
                tick  = &div_q;
                div_d = div_q + 1'b1;
            end
            default: begin
                tick  = 1'b0;
                div_d = '0;
            end
        endcase
        if (restart) begin
            div_d = '0;
        end
    end

endmodule

// File: rtl/tmr16_count.sv
module tmr16_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);

    logic [CNT_W-1:0] cnt_q;

    assign ovf = tick && !load && (&cnt_q);
    assign cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs #(
    parameter int              DATA_W = 8,
    parameter int              ADDR_W = 8,
    parameter logic [ADDR_W-1:0] A_CTLA = 8'h80,
    parameter logic [ADDR_W-1:0] A_CTLB = 8'h81,
    parameter logic [ADDR_W-1:0] A_CNTL = 8'h84,
    parameter logic [ADDR_W-1:0] A_CNTH = 8'h85,
    parameter logic [ADDR_W-1:0] A_MASK = 8'h6F,
    parameter logic [ADDR_W-1:0] A_FLAG = 8'h36,
    localparam int             CNT_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              irq_ack,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              ovf,
    output logic [DATA_W-1:0] temp,
    output logic              load,
    output logic              cs_wr,
    output logic [2:0]        cs_new,
    output logic [2:0]        cs_cur,
    output logic              mask,
    output logic              flag,
    output logic [DATA_W-1:0] bus_rdata
);

    logic [DATA_W-1:0] temp_q;
    logic [DATA_W-1:0] ctla_q;
    logic [2:0]        cs_q;
    logic              mask_q;
    logic              flag_q;
    logic              wr_ctla;
    logic              wr_mask;
    logic              wr_flag;
    logic              wr_hi;
    logic              rd_lo;
    logic              flag_clr;

    assign wr_ctla  = bus_wr && (bus_addr == A_CTLA);
    assign cs_wr    = bus_wr && (bus_addr == A_CTLB);
    assign load     = bus_wr && (bus_addr == A_CNTL);
    assign wr_hi    = bus_wr && (bus_addr == A_CNTH);
    assign wr_mask  = bus_wr && (bus_addr == A_MASK);
    assign wr_flag  = bus_wr && (bus_addr == A_FLAG);
    assign rd_lo    = bus_rd && (bus_addr == A_CNTL);
    assign flag_clr = (wr_flag && bus_wdata[0]) || irq_ack;

    assign cs_new = bus_wdata[2:0];
    assign cs_cur = cs_q;
    assign temp   = temp_q;
    assign mask   = mask_q;
    assign flag   = flag_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            temp_q <= '0;
            ctla_q <= '0;
            cs_q   <= '0;
            mask_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr_hi) begin
                temp_q <= bus_wdata;
            end else if (rd_lo) begin
                temp_q <= cnt[CNT_W-1:DATA_W];
            end
            if (wr_ctla) begin
                ctla_q <= bus_wdata;
            end
            if (cs_wr) begin
                cs_q <= bus_wdata[2:0];
            end
            if (wr_mask) begin
                mask_q <= bus_wdata[0];
            end
            if (ovf) begin
                flag_q <= 1'b1;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_CTLA:  bus_rdata = ctla_q;
                A_CTLB:  bus_rdata = {{(DATA_W-3){1'b0}}, cs_q};
                A_CNTL:  bus_rdata = cnt[DATA_W-1:0];
                A_CNTH:  bus_rdata = temp_q;
                A_MASK:  bus_rdata = {{(DATA_W-1){1'b0}}, mask_q};
                A_FLAG:  bus_rdata = {{(DATA_W-1){1'b0}}, flag_q};
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/tmr16_ovf_timer.sv
module tmr16_ovf_timer #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int PRE_W  = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              gie,
    input  logic              irq_ack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic              tick_w;
    logic              load_w;
    logic              ovf_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [DATA_W-1:0] temp_w;
    logic              cs_wr_w;
    logic [2:0]        cs_new_w;
    logic [2:0]        cs_cur_w;
    logic              mask_w;
    logic              flag_w;

    tmr16_regs #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .irq_ack  (irq_ack),
        .cnt      (cnt_w),
        .ovf      (ovf_w),
        .temp     (temp_w),
        .load     (load_w),
        .cs_wr    (cs_wr_w),
        .cs_new   (cs_new_w),
        .cs_cur   (cs_cur_w),
        .mask     (mask_w),
        .flag     (flag_w),
        .bus_rdata(bus_rdata)
    );

    tmr16_prescale #(
        .PRE_W(PRE_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_wr (cs_wr_w),
        .cs_new(cs_new_w),
        .cs_cur(cs_cur_w),
        .tick  (tick_w)
    );

    tmr16_count #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_w),
        .load    (load_w),
        .load_val({temp_w, bus_wdata}),
        .cnt     (cnt_w),
        .ovf     (ovf_w)
    );

    assign irq = flag_w && mask_w && gie;

endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    localparam int CNT_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              gie,
    input logic              irq_ack,
    input logic              irq,
    input logic              tick,
    input logic              ovf,
    input logic [CNT_W-1:0]  cnt,
    input logic [DATA_W-1:0] temp,
    input logic [2:0]        cs,
    input logic              flag
);

    localparam logic [ADDR_W-1:0] A_CNTL = 8'h84;
    localparam logic [ADDR_W-1:0] A_CNTH = 8'h85;

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(bus_wr && bus_addr == A_CNTL) && (&cnt)) |=> (cnt == '0 && flag)); // R2

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs == 3'b000 && !(bus_wr && bus_addr == A_CNTL)) |=> $stable(cnt)); // R3

    AST_HIGH_WRITE_TEMP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CNTH && !tick) |=> ($stable(cnt) && temp == $past(bus_wdata))); // R5

    AST_LOW_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CNTL) |=> (cnt == $past({temp, bus_wdata}))); // R6

    AST_LOW_READ_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == A_CNTL) |=> (temp == $past(cnt[CNT_W-1:DATA_W]))); // R7

    AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> gie); // R8

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !ovf) |=> !flag); // R9

endmodule

bind tmr16_ovf_timer tmr16_chk #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_wdata(bus_wdata),
    .gie      (gie),
    .irq_ack  (irq_ack),
    .irq      (irq),
    .tick     (tick_w),
    .ovf      (ovf_w),
    .cnt      (cnt_w),
    .temp     (temp_w),
    .cs       (cs_cur_w),
    .flag     (flag_w)
);

// File: tb/tmr16_ovf_timer_tb_top.sv
`timescale 1ns/100ps
module tmr16_ovf_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       gie = 1'b0;
    logic       irq_ack = 1'b0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    // reference model state
    int m_cnt, m_temp, m_ctla, m_cs, m_pre;
    bit m_mask, m_flag;

    always #2.5 clk = ~clk;

    tmr16_ovf_timer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .gie      (gie),
        .irq_ack  (irq_ack),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_temp = 0; m_ctla = 0; m_cs = 0; m_pre = 0;
            m_mask = 0; m_flag = 0;
        end else begin
            bit tk, ld, ov;
            int n_cnt, n_temp, n_pre;
            bit n_flag;
            tk = (m_cs == 1) || (m_cs == 4 && m_pre == 255);
            ld = bus_wr && bus_addr == 8'h84;
            ov = tk && !ld && m_cnt == 16'hFFFF;
            n_cnt = ld ? (m_temp * 256 + bus_wdata) : (tk ? (m_cnt + 1) % 65536 : m_cnt);
            if (bus_wr && bus_addr == 8'h81 && int'(bus_wdata[2:0]) != m_cs) n_pre = 0;
            else if (m_cs == 4) n_pre = (m_pre + 1) % 256;
            else n_pre = 0;
            n_temp = m_temp;
            if (bus_wr && bus_addr == 8'h85) n_temp = bus_wdata;
            else if (bus_rd && bus_addr == 8'h84) n_temp = m_cnt / 256;
            n_flag = m_flag;
            if (ov) n_flag = 1;
            else if ((bus_wr && bus_addr == 8'h36 && bus_wdata[0]) || irq_ack) n_flag = 0;
            if (bus_wr && bus_addr == 8'h80) m_ctla = bus_wdata;
            if (bus_wr && bus_addr == 8'h81) m_cs = bus_wdata[2:0];
            if (bus_wr && bus_addr == 8'h6F) m_mask = bus_wdata[0];
            m_cnt = n_cnt; m_temp = n_temp; m_pre = n_pre; m_flag = n_flag;
        end
    end

    function automatic int m_read(input logic [7:0] a);
        case (a)
            8'h80: return m_ctla;
            8'h81: return m_cs;
            8'h84: return m_cnt % 256;
            8'h85: return m_temp;
            8'h6F: return m_mask;
            8'h36: return m_flag;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // R8: irq compared against the model on every cycle
    always @(negedge clk) begin
        #1;
        if (live) check("R8 irq", irq, int'(m_flag && m_mask && gie));
    end

    // R11: read data idle when no read strobe
    always @(negedge clk) begin
        #1.5;
        if (live && !bus_rd) check("R11 idle rdata", bus_rdata, 0);
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check(tag, bus_rdata, m_read(a));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_lit(input logic [7:0] a, input int exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        check(tag, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;
        // R1 reset state
        gie = 1'b1;
        rd_lit(8'h80, 0, "R1 ctla");
        rd_lit(8'h81, 0, "R1 cs");
        rd_lit(8'h84, 0, "R1 low");
        rd_lit(8'h85, 0, "R1 high");
        rd_lit(8'h6F, 0, "R1 mask");
        rd_lit(8'h36, 0, "R1 flag");
        check("R1 irq", irq, 0);
        // R5 high write touches only holding register
        wr(8'h85, 8'h12);
        rd_lit(8'h84, 8'h00, "R5 low unchanged");
        rd_lit(8'h85, 8'h00, "R7 high after low read");
        // R6 atomic write
        wr(8'h85, 8'h12);
        wr(8'h84, 8'h34);
        rd_lit(8'h84, 8'h34, "R6 low");
        rd_lit(8'h85, 8'h12, "R6 high");
        // R10 control A
        wr(8'h80, 8'hA5);
        idle(5);
        rd_lit(8'h80, 8'hA5, "R10 readback");
        rd_lit(8'h84, 8'h34, "R10 no counting");
        // R11 unmapped
        wr(8'h10, 8'hFF);
        rd_lit(8'h10, 0, "R11 unmapped");
        rd_lit(8'h84, 8'h34, "R11 count kept");
        // R3 divide-by-1 and R2 wrap
        wr(8'h85, 8'hFF);
        wr(8'h84, 8'hF0);
        wr(8'h6F, 8'h01);
        wr(8'h81, 8'h01);
        rd(8'h81, "R3 cs readback");
        idle(20);
        rd_lit(8'h36, 1, "R2 flag after wrap");
        check("R8 irq high", irq, 1);
        gie = 1'b0;
        idle(2);
        check("R8 irq gated by gie", irq, 0);
        gie = 1'b1;
        // R7 split read while running
        rd(8'h84, "R7 low live");
        idle(3);
        rd(8'h85, "R7 high latched");
        // R9 clear rules
        wr(8'h36, 8'h00);
        rd_lit(8'h36, 1, "R9 write 0 keeps");
        wr(8'h36, 8'h01);
        rd_lit(8'h36, 0, "R9 write 1 clears");
        wr(8'h85, 8'hFF);
        wr(8'h84, 8'hFE);
        idle(4);
        rd_lit(8'h36, 1, "R2 flag again");
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        rd_lit(8'h36, 0, "R9 ack clears");
        wr(8'h85, 8'hFF);
        wr(8'h84, 8'hFF);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        rd_lit(8'h36, 1, "R9 set wins over ack");
        // R6 load beats tick at 0xFFFF
        wr(8'h81, 8'h00);
        wr(8'h85, 8'hFF);
        wr(8'h84, 8'hFF);
        wr(8'h85, 8'h00);
        wr(8'h36, 8'h01);
        wr(8'h81, 8'h01);
        wr(8'h84, 8'h10);
        wr(8'h81, 8'h00);
        rd_lit(8'h36, 0, "R6 no overflow on load");
        rd_lit(8'h84, 8'h11, "R6 loaded then one tick");
        // R3 other code is stopped
        wr(8'h81, 8'h03);
        idle(10);
        rd_lit(8'h84, 8'h11, "R3 code 3 stopped");
        rd_lit(8'h81, 8'h03, "R3 code readback");
        // R3/R4 divide-by-256 spacing
        wr(8'h85, 8'hFF);
        wr(8'h84, 8'hFF);
        wr(8'h36, 8'h01);
        wr(8'h81, 8'h04);
        idle(250);
        rd_lit(8'h36, 0, "R4 no tick before 256");
        idle(10);
        rd_lit(8'h36, 1, "R4 tick at 256");
        rd_lit(8'h84, 8'h00, "R2 wrapped to zero");
        // R4 restart on code change
        idle(100);
        wr(8'h81, 8'h03);
        wr(8'h81, 8'h04);
        idle(200);
        rd(8'h84, "R4 restart before tick");
        idle(100);
        rd(8'h84, "R4 restart after tick");
        idle(3);
        finish_run();
    end

endmodule